// File: doc/BRIEF.md
# Two-Way Write-Through Cache

This block sits between a 32-bit pipelined processor and a word-oriented memory bus. It holds recently read lines in a two-way set-associative store. A read that finds its line returns the word one cycle after it is accepted. A read that misses stalls the processor while all four words of the line are fetched from memory, one handshake per word. The requested word is then returned, and the stall drops in the same cycle.

Every store goes out to memory. A store that finds its line also updates the cached copy under its byte enables, and a store that misses leaves the cache untouched. On a miss, an empty way in the set is always filled first. When both ways are full, a free-running shift register picks the victim at random.

A separate invalidate input carries store addresses from the data side. This lets an instruction-side copy of this cache drop any line that a store has changed, so fetches never see stale code and software never has to flush the cache. The capacity is a parameter, and the number of sets and the tag width follow from it.

Top module: `wtc_cache`

## Requirements
- R1: After reset every line is invalid, `cpuStall`, `cpuRvalid` and `memReq` are low, and the first read of any address misses.
- R2: A read miss raises `cpuStall` in the cycle after it is accepted and holds it until the line is complete. In the cycle after the last word arrives, `cpuRvalid` is high with the requested word and `cpuStall` is low.
- R3: A read hit raises `cpuRvalid` with the correct word in the cycle after acceptance and makes no memory request.
- R4: Every store is posted to memory with its word address, data and byte enables. `cpuStall` stays high until `memAck`.
- R5: On a store hit, the cached word is updated only in the bytes whose enable is set. Enable bit b covers data bits 8b+7 to 8b.
- R6: A store miss allocates nothing, so a later read of that line still misses.
- R7: Two lines that share an index can be resident together, one per way, and the two ways of a set never hold the same line.
- R8: A miss fills an invalid way of the set when there is one. Otherwise a pseudo-random bit selects the victim, and exactly one of the two old lines is evicted.
- R9: When `invValid` is high, a line whose index and tag match `invAddr` is invalid from the next cycle. The other way and the other sets are unaffected. The word offset of `invAddr` is ignored.
- R10: An invalidate that hits the line being refilled, in the cycle the miss is accepted or while the refill is in progress, leaves that line invalid after the refill. The stalled read still returns the fetched word.
- R11: The address is split, from the least significant bit, into 2 byte bits, the word offset in bits [3:2], the index in the next log2(sets) bits, and the tag in the rest. There are capacity/32 sets. A refill reads the words of the line base at offsets 0, 4, 8 and 12 in that order.
- R12: While `memReq` is high and `memAck` has not come, `memReq`, `memAddr` and the other request fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Processor request; accepted when `cpuStall` is low |
| cpuWe | input | 1 | 1 = store, 0 = read |
| cpuAddr | input | 32 | Byte address of the request |
| cpuWdata | input | 32 | Store data |
| cpuBe | input | 4 | Store byte enables |
| cpuRdata | output | 32 | Read data, valid with `cpuRvalid` |
| cpuRvalid | output | 1 | One-cycle pulse marking returned read data |
| cpuStall | output | 1 | High while a refill or a store is in progress |
| invValid | input | 1 | Invalidate strobe |
| invAddr | input | 32 | Address whose line is to be dropped |
| memReq | output | 1 | Memory request, held until `memAck` |
| memWe | output | 1 | Memory write |
| memAddr | output | 32 | Word-aligned memory address |
| memWdata | output | 32 | Memory write data |
| memBe | output | 4 | Memory byte enables (all set for reads) |
| memRdata | input | 32 | Memory read data, valid with `memAck` |
| memAck | input | 1 | Memory handshake completion |

## Verification
Some properties are checked by assertions on every cycle. A set never hits in both ways. A hit returns data without touching the bus. A store always turns into a held memory write. A matching invalidate always clears the valid bit, even in the middle of a refill. The request fields stay frozen until the handshake completes. Other behaviour needs the bench's scenarios: that the data returned is correct after refills and byte-masked stores, that a store miss allocates nothing, that an empty way is preferred over the random choice, and that exactly one line survives an eviction. The bench shows these only through sequences of reads whose bus traffic and latency reveal which lines are resident.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_STORE
  } wtc_state_t;

  typedef struct packed {
    logic rdHit;       // accepted read that hits
    logic startFill;   // accepted read that misses
    logic fillWord;    // refill word arrives
    logic fillLast;    // last refill word arrives
    logic storeAccept; // accepted store
  } wtc_strobe_t;
endpackage

// File: rtl/wtc_lfsr.sv
module wtc_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 'hB8,
  parameter logic [W-1:0] SEED = 'h5A
) (
  input  logic clk,
  input  logic rstN,
  output logic pick
);
  logic [W-1:0] state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEED;
    else if (state[0]) state <= (state >> 1) ^ TAPS;
    else state <= state >> 1;
  end

  assign pick = state[0];

  // R8: the random source never locks up in the all-zero state
  a_r8_lfsr_alive: assert property (@(posedge clk) disable iff (!rstN) state != '0);
endmodule

// File: rtl/wtc_datapath.sv
module wtc_datapath import wtc_pkg::*; #(
  parameter int CAP_BYTES  = 4096,
  parameter int LINE_WORDS = 4,
  parameter int LFSR_W     = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 'h5A
) (
  input  logic        clk,
  input  logic        rstN,
  input  wtc_strobe_t strb,
  input  logic        fsmFill,
  input  logic        memBusy,
  input  logic [31:0] cpuAddr,
  input  logic [31:0] cpuWdata,
  input  logic [3:0]  cpuBe,
  input  logic        invValid,
  input  logic [31:0] invAddr,
  input  logic [31:0] memRdata,
  input  logic        memAck,
  output logic        anyHit,
  output logic        lastWord,
  output logic [31:0] cpuRdata,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [3:0]  memBe
);
  localparam int LINE_BYTES = LINE_WORDS * 4;
  localparam int SETS       = CAP_BYTES / (WAYS * LINE_BYTES);
  localparam int OFF_W      = $clog2(LINE_WORDS);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = 32 - IDX_W - OFF_W - 2;
  localparam int WAY_WORDS  = SETS * LINE_WORDS;

  // address split
  logic [OFF_W-1:0] reqOff;
  logic [IDX_W-1:0] reqIdx, invIdx;
  logic [TAG_W-1:0] reqTag, invTag;
  assign reqOff = cpuAddr[2 +: OFF_W];
  assign reqIdx = cpuAddr[2+OFF_W +: IDX_W];
  assign reqTag = cpuAddr[31 -: TAG_W];
  assign invIdx = invAddr[2+OFF_W +: IDX_W];
  assign invTag = invAddr[31 -: TAG_W];

  // refill and store registers
  logic [TAG_W-1:0] fillTagQ;
  logic [IDX_W-1:0] fillIdxQ;
  logic [OFF_W-1:0] fillOffQ, cntQ;
  logic             victimQ, poisonQ;
  logic [29:0]      storeWordQ;
  logic [31:0]      storeDataQ, rdataQ;
  logic [3:0]       storeBeQ;

  logic [WAYS-1:0]  hitVec, setValid, invMatch;
  logic [31:0]      wayWord [WAYS];
  logic             pick, victimSel, invFillHit, reqInvHit, keepFill;

  wtc_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) uLfsr (
    .clk(clk), .rstN(rstN), .pick(pick)
  );

  assign invFillHit = invValid && invTag == fillTagQ && invIdx == fillIdxQ;
  assign reqInvHit  = invValid && invTag == reqTag && invIdx == reqIdx;
  assign keepFill   = !(poisonQ || invFillHit);
  assign victimSel  = !setValid[0] ? 1'b0 : (!setValid[1] ? 1'b1 : pick);

  for (genvar w = 0; w < WAYS; w++) begin : gWay
    logic [SETS-1:0]  validQ;
    logic [TAG_W-1:0] tagMem  [SETS];
    logic [31:0]      dataMem [WAY_WORDS];
    logic             fillHere;

    assign fillHere    = strb.fillLast && victimQ == w[0];
    assign setValid[w] = validQ[reqIdx];
    assign hitVec[w]   = validQ[reqIdx] && tagMem[reqIdx] == reqTag;
    assign invMatch[w] = validQ[invIdx] && tagMem[invIdx] == invTag;
    assign wayWord[w]  = dataMem[{reqIdx, reqOff}];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ <= '0;
      else begin
        if (invValid && invMatch[w] && !(fillHere && fillIdxQ == invIdx))
          validQ[invIdx] <= 1'b0;
        if (fillHere) validQ[fillIdxQ] <= keepFill;
      end
    end

    always_ff @(posedge clk) begin
      if (fillHere) tagMem[fillIdxQ] <= fillTagQ;
      if (strb.fillWord && victimQ == w[0])
        dataMem[{fillIdxQ, cntQ}] <= memRdata;
      else if (strb.storeAccept && hitVec[w])
        for (int b = 0; b < 4; b++)
          if (cpuBe[b]) dataMem[{reqIdx, reqOff}][8*b +: 8] <= cpuWdata[8*b +: 8];
    end

    // R9: a matching invalidate leaves the line invalid next cycle
    a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rstN)
      (invValid && invMatch[w] && !fillHere) |=> !validQ[$past(invIdx)]);
    // R10: a refill hit by an invalidate in its last cycle stays invalid
    a_r10_poisoned_fill: assert property (@(posedge clk) disable iff (!rstN)
      (fillHere && invFillHit) |=> !validQ[$past(fillIdxQ)]);
  end

  assign anyHit   = |hitVec;
  assign lastWord = cntQ == OFF_W'(LINE_WORDS - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillTagQ <= '0; fillIdxQ <= '0; fillOffQ <= '0; cntQ <= '0;
      victimQ <= 1'b0; poisonQ <= 1'b0; rdataQ <= '0;
      storeWordQ <= '0; storeDataQ <= '0; storeBeQ <= '0;
    end else begin
      if (strb.startFill) begin
        fillTagQ <= reqTag;
        fillIdxQ <= reqIdx;
        fillOffQ <= reqOff;
        cntQ     <= '0;
        victimQ  <= victimSel;
        poisonQ  <= reqInvHit;
      end else begin
        if (invFillHit) poisonQ <= 1'b1;
        if (strb.fillWord) cntQ <= cntQ + 1'b1;
      end
      if (strb.rdHit) rdataQ <= hitVec[1] ? wayWord[1] : wayWord[0];
      else if (strb.fillWord && cntQ == fillOffQ) rdataQ <= memRdata;
      if (strb.storeAccept) begin
        storeWordQ <= cpuAddr[31:2];
        storeDataQ <= cpuWdata;
        storeBeQ   <= cpuBe;
      end
    end
  end

  assign cpuRdata = rdataQ;
  assign memAddr  = fsmFill ? {fillTagQ, fillIdxQ, cntQ, 2'b00} : {storeWordQ, 2'b00};
  assign memWdata = storeDataQ;
  assign memBe    = fsmFill ? 4'hF : storeBeQ;

  logic unusedDp;
  assign unusedDp = ^{cpuAddr[1:0], invAddr[1+OFF_W:0], memAck, memBusy};

  // R7: a set never holds the same line in both ways
  a_r7_single_way: assert property (@(posedge clk) disable iff (!rstN) $onehot0(hitVec));
  // R12: the bus address holds until the handshake completes
  a_r12_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (memBusy && !memAck) |=> $stable(memAddr) && $stable(memBe) && $stable(memWdata));
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl import wtc_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        anyHit,
  input  logic        lastWord,
  input  logic        memAck,
  output wtc_strobe_t strb,
  output logic        fsmFill,
  output logic        memReq,
  output logic        memWe,
  output logic        cpuStall,
  output logic        cpuRvalid
);
  wtc_state_t state, stateNext;
  logic accept, rvalidQ;

  assign accept = cpuReq && state == ST_IDLE;

  always_comb begin
    strb.rdHit       = accept && !cpuWe && anyHit;
    strb.startFill   = accept && !cpuWe && !anyHit;
    strb.storeAccept = accept && cpuWe;
    strb.fillWord    = state == ST_FILL && memAck;
    strb.fillLast    = strb.fillWord && lastWord;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strb.startFill) stateNext = ST_FILL;
                else if (strb.storeAccept) stateNext = ST_STORE;
      ST_FILL:  if (strb.fillLast) stateNext = ST_IDLE;
      ST_STORE: if (memAck) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rvalidQ <= 1'b0;
    end else begin
      state   <= stateNext;
      rvalidQ <= strb.rdHit || strb.fillLast;
    end
  end

  assign fsmFill   = state == ST_FILL;
  assign memReq    = state != ST_IDLE;
  assign memWe     = state == ST_STORE;
  assign cpuStall  = state != ST_IDLE;
  assign cpuRvalid = rvalidQ;

  // R3: a hit answers next cycle without using the bus
  a_r3_hit_no_bus: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdHit |=> cpuRvalid && !memReq && !cpuStall);
  // R2: a miss stalls from the next cycle and returns no data yet
  a_r2_miss_stalls: assert property (@(posedge clk) disable iff (!rstN)
    strb.startFill |=> cpuStall && !cpuRvalid && memReq && !memWe);
  // R2: completing the line releases the stall with data
  a_r2_fill_release: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillLast |=> cpuRvalid && !cpuStall);
  // R4: every store becomes a held memory write
  a_r4_store_posted: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeAccept |=> memReq && memWe && cpuStall);
  // R12: a request is never withdrawn before its acknowledge
  a_r12_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache import wtc_pkg::*; #(
  parameter int CAP_BYTES  = 4096,
  parameter int LINE_WORDS = 4,
  parameter int LFSR_W     = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic [31:0] cpuAddr,
  input  logic [31:0] cpuWdata,
  input  logic [3:0]  cpuBe,
  output logic [31:0] cpuRdata,
  output logic        cpuRvalid,
  output logic        cpuStall,
  input  logic        invValid,
  input  logic [31:0] invAddr,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [3:0]  memBe,
  input  logic [31:0] memRdata,
  input  logic        memAck
);
  wtc_strobe_t strb;
  logic anyHit, lastWord, fsmFill;

  wtc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .anyHit(anyHit), .lastWord(lastWord), .memAck(memAck),
    .strb(strb), .fsmFill(fsmFill), .memReq(memReq), .memWe(memWe),
    .cpuStall(cpuStall), .cpuRvalid(cpuRvalid)
  );

  wtc_datapath #(.CAP_BYTES(CAP_BYTES), .LINE_WORDS(LINE_WORDS), .LFSR_W(LFSR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .fsmFill(fsmFill), .memBusy(memReq),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuBe(cpuBe),
    .invValid(invValid), .invAddr(invAddr),
    .memRdata(memRdata), .memAck(memAck),
    .anyHit(anyHit), .lastWord(lastWord), .cpuRdata(cpuRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe)
  );
endmodule

// File: tb/sim_wtc_cache.sv
`timescale 1ns/1ps
module sim_wtc_cache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic [3:0]  cpuBe = '0;
  logic [31:0] cpuRdata;
  logic        cpuRvalid, cpuStall;
  logic        invValid = 1'b0;
  logic [31:0] invAddr = '0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [3:0]  memBe;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  int checks = 0, fails = 0;
  int memLat = 1, waitCnt = 0;
  int rdCount = 0, wrCount = 0, hsErr = 0;
  logic [31:0] rdLog [4];
  logic [31:0] lastWrAddr = '0;
  logic [3:0]  lastWrBe = '0;
  logic [31:0] memArr [1024];
  logic [31:0] golden [1024];
  logic        prevPend = 1'b0;
  logic [31:0] prevAddr = '0;
  bit          done = 1'b0;

  wtc_cache #(.CAP_BYTES(128)) u0 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuBe(cpuBe), .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid),
    .cpuStall(cpuStall), .invValid(invValid), .invAddr(invAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memBe(memBe), .memRdata(memRdata), .memAck(memAck)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] memInit(int i);
    return (i * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  // 8 sets of 2 ways? no: 128 bytes / (2 ways * 16 bytes) = 4 sets; tag from bit 6
  function automatic logic [31:0] mkAddr(int tag, int set, int w);
    return 32'((tag << 6) | (set << 4) | (w << 2));
  endfunction

  // memory model with programmable latency
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 1024; i++) memArr[i] <= memInit(i);
      memAck <= 1'b0;
      waitCnt <= 0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        if (waitCnt >= memLat - 1) begin
          memAck <= 1'b1;
          waitCnt <= 0;
          if (memWe) begin
            memArr[memAddr[11:2]] <= merge(memArr[memAddr[11:2]], memWdata, memBe);
            wrCount <= wrCount + 1;
            lastWrAddr <= memAddr;
            lastWrBe <= memBe;
          end else begin
            memRdata <= memArr[memAddr[11:2]];
            rdCount <= rdCount + 1;
            rdLog[0] <= rdLog[1]; rdLog[1] <= rdLog[2]; rdLog[2] <= rdLog[3];
            rdLog[3] <= memAddr;
          end
        end else waitCnt <= waitCnt + 1;
      end
    end
  end

  // handshake stability monitor (R12)
  always @(negedge clk) begin
    if (rstN) begin
      if (prevPend && (!memReq || memAddr != prevAddr)) hsErr <= hsErr + 1;
      prevPend <= memReq && !memAck;
      prevAddr <= memAddr;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doRead(logic [31:0] a, output logic [31:0] d, output int lat,
                        output int nrd, output bit stall1, output bit stallEnd);
    int r0;
    @(negedge clk);
    while (cpuStall) @(negedge clk);
    r0 = rdCount;
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = a;
    @(negedge clk);
    cpuReq = 1'b0;
    lat = 1;
    stall1 = cpuStall;
    while (!cpuRvalid && lat < 200) begin @(negedge clk); lat++; end
    d = cpuRdata;
    stallEnd = cpuStall;
    nrd = rdCount - r0;
  endtask

  task automatic expectRead(logic [31:0] a, bit expHit, string req);
    logic [31:0] d; int lat, nrd; bit s1, se;
    logic [31:0] base;
    doRead(a, d, lat, nrd, s1, se);
    check(d == golden[a[11:2]], req, d, golden[a[11:2]]);
    if (expHit) begin
      check(lat == 1 && nrd == 0, req, 32'(lat * 16 + nrd), 32'h10);
    end else begin
      check(nrd == 4, req, 32'(nrd), 32'd4);
      check(s1 && !se, "R2", {30'd0, s1, se}, 32'd2);
      base = {a[31:4], 4'h0};
      for (int k = 0; k < 4; k++)
        check(rdLog[k] == base + 32'(4 * k), "R11", rdLog[k], base + 32'(4 * k));
    end
  endtask

  task automatic doWrite(logic [31:0] a, logic [31:0] dat, logic [3:0] be);
    int w0;
    @(negedge clk);
    while (cpuStall) @(negedge clk);
    w0 = wrCount;
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = a; cpuWdata = dat; cpuBe = be;
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
    check(cpuStall == 1'b1, "R4", {31'd0, cpuStall}, 32'd1);
    while (cpuStall) @(negedge clk);
    golden[a[11:2]] = merge(golden[a[11:2]], dat, be);
    check(wrCount - w0 == 1, "R4", 32'(wrCount - w0), 32'd1);
    check(lastWrAddr == {a[31:2], 2'b00} && lastWrBe == be, "R4",
          {lastWrAddr[27:0], lastWrBe}, {a[27:2], 2'b00, be});
    check(memArr[a[11:2]] == golden[a[11:2]], "R4", memArr[a[11:2]], golden[a[11:2]]);
  endtask

  task automatic pulseInv(logic [31:0] a);
    @(negedge clk);
    invValid = 1'b1; invAddr = a;
    @(negedge clk);
    invValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; int lat, nrd; bit s1, se;
    for (int i = 0; i < 1024; i++) golden[i] = memInit(i);
    for (int k = 0; k < 4; k++) rdLog[k] = '0;
    repeat (3) @(negedge clk);
    check(!cpuStall && !cpuRvalid && !memReq, "R1",
          {29'd0, cpuStall, cpuRvalid, memReq}, 32'd0);
    rstN = 1'b1;

    // cold misses in every set, then every word hits (R1, R2, R3, R11)
    for (int s = 0; s < 4; s++) begin
      memLat = 1 + s % 3;
      expectRead(mkAddr(1, s, s), 1'b0, "R1");
      for (int w = 0; w < 4; w++) expectRead(mkAddr(1, s, w), 1'b1, "R3");
    end
    // second way of each set; both lines stay (R7, R8 empty way first)
    for (int s = 0; s < 4; s++) begin
      expectRead(mkAddr(2, s, 0), 1'b0, "R7");
      expectRead(mkAddr(1, s, 1), 1'b1, "R8");
      expectRead(mkAddr(2, s, 3), 1'b1, "R7");
    end
    // store hits under every byte-enable pattern (R4, R5)
    memLat = 2;
    for (int be = 0; be < 16; be++) begin
      doWrite(mkAddr(1, 0, be % 4), 32'hC0DE_0000 + 32'(be * 32'h0101_0111), 4'(be));
      expectRead(mkAddr(1, 0, be % 4), 1'b1, "R5");
    end
    // store miss allocates nothing (R6)
    doWrite(mkAddr(4, 1, 2), 32'h1234_5678, 4'b1111);
    expectRead(mkAddr(4, 1, 2), 1'b0, "R6");
    // eviction in a full set (R8)
    expectRead(mkAddr(3, 2, 0), 1'b0, "R8");
    expectRead(mkAddr(3, 2, 1), 1'b1, "R8");
    doRead(mkAddr(1, 2, 0), d, lat, nrd, s1, se);
    check(d == golden[mkAddr(1, 2, 0) >> 2], "R8", d, golden[mkAddr(1, 2, 0) >> 2]);
    if (nrd == 0) expectRead(mkAddr(2, 2, 0), 1'b0, "R8");
    // invalidate via another word of the line (R9)
    pulseInv(mkAddr(2, 3, 1));
    expectRead(mkAddr(2, 3, 0), 1'b0, "R9");
    expectRead(mkAddr(1, 3, 2), 1'b1, "R9");
    expectRead(mkAddr(1, 0, 0), 1'b1, "R9");
    pulseInv(mkAddr(5, 0, 0));
    expectRead(mkAddr(1, 0, 3), 1'b1, "R9");
    expectRead(mkAddr(2, 0, 2), 1'b1, "R9");
    // invalidate during a refill of the same line (R10)
    @(negedge clk);
    while (cpuStall) @(negedge clk);
    nrd = rdCount;
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = mkAddr(5, 3, 1);
    @(negedge clk);
    cpuReq = 1'b0;
    check(cpuStall, "R2", {31'd0, cpuStall}, 32'd1);
    @(negedge clk);
    @(negedge clk);
    invValid = 1'b1; invAddr = mkAddr(5, 3, 2);
    @(negedge clk);
    invValid = 1'b0;
    lat = 0;
    while (!cpuRvalid && lat < 200) begin @(negedge clk); lat++; end
    check(cpuRdata == golden[mkAddr(5, 3, 1) >> 2], "R10", cpuRdata, golden[mkAddr(5, 3, 1) >> 2]);
    check(rdCount - nrd == 4, "R10", 32'(rdCount - nrd), 32'd4);
    expectRead(mkAddr(5, 3, 1), 1'b0, "R10");
    expectRead(mkAddr(5, 3, 2), 1'b1, "R10");
    // invalidate in the accept cycle of the miss (R10)
    pulseInv(mkAddr(5, 3, 0));
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = mkAddr(5, 3, 0);
    invValid = 1'b1; invAddr = mkAddr(5, 3, 3);
    @(negedge clk);
    cpuReq = 1'b0; invValid = 1'b0;
    while (!cpuRvalid) @(negedge clk);
    expectRead(mkAddr(5, 3, 0), 1'b0, "R10");

    check(hsErr == 0, "R12", 32'(hsErr), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule